// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block sits between a group of processing elements and a single write port of a shared memory. In any clock cycle, any of the elements may raise a write request carrying an address and a data word. The block chooses one target address for the cycle. It applies a runtime-selected policy to every element that aims at that address, and then drives one memory write (enable, address, data) together with a two-bit outcome code for each element.

Four policies are available. The first stores the value only when all contenders agree. The second lets a rotating choice pick one contender. The third lets the lowest element index win. The fourth stores the wrapped sum of all contending values and raises an overflow flag when the true sum does not fit. Requests, policy and outcome all pass through one register stage, so each result appears one cycle after its request. Reads need no arbitration, so they do not pass through this block.

Top module: `cw_resolver`

## Requirements
- R1: While reset is asserted and right after it, memWe, memAddr, memData and sumOverflow are 0, and every element's status is IDLE (code 0).
- R2: Each cycle's requests and mode are captured at a rising clock edge. The write port, overflow flag and status codes for that cycle are valid after that same edge, which is one cycle of latency.
- R3: The target address is the address of the lowest-index element whose wrValid bit is set. A valid element with a different address gets RETRY (code 3). An element without a valid request gets IDLE (code 0). The status of element i sits at peStatus[2i+1:2i].
- R4: In mode 0 (all-agree), the target is written only if every contender's data is identical, and each contender then gets DONE (code 1). If any contender's data differs, memWe stays low and every contender gets FAIL (code 2).
- R5: In mode 2 (ranked), the contender with the lowest index is written and gets DONE. All other contenders get FAIL.
- R6: In mode 1 (rotating), exactly one contender gets DONE and its data is written. The winner is the first contender found scanning upward with wraparound from a pointer. The pointer is 0 after reset and moves to winner+1 (mod NUM_PE) after every mode-1 cycle that has a valid request.
- R7: In mode 3 (summing), the sum of all contenders' data modulo 2^DATA_W is written, and every contender gets DONE.
- R8: sumOverflow is 1 exactly when a mode-3 write's true sum is 2^DATA_W or larger. It is 0 in all other cases.
- R9: A cycle without a committed write gives memWe=0, memAddr=0 and memData=0. This includes a cycle with no valid request.
- R10: A change of mode applies to the requests captured at the same edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Policy: 0 all-agree, 1 rotating, 2 ranked, 3 summing |
| wrValid | input | NUM_PE | Write request per element |
| wrAddr | input | NUM_PE*ADDR_W | Packed addresses, element i at [i*ADDR_W +: ADDR_W] |
| wrData | input | NUM_PE*DATA_W | Packed data, element i at [i*DATA_W +: DATA_W] |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| sumOverflow | output | 1 | True sum exceeded range in summing mode |
| peStatus | output | 2*NUM_PE | Per-element outcome: 0 idle, 1 done, 2 fail, 3 retry |

## Verification
Every result is due exactly one rising edge after the requests are applied: the write port, the overflow flag and all status codes. This includes the effect of a mode change and the rotating pointer's new position. The driver applies each request set on a falling edge and queues the expected outcome at that moment. The monitor takes one item from the queue 2 ns after each rising edge and compares it, so it always compares the registered result of the requests from the half-cycle before. Idle cycles are queued as well, which also checks that a write does not persist into the next cycle.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  typedef enum logic [1:0] {
    MODE_AGREE  = 2'd0,
    MODE_ROTATE = 2'd1,
    MODE_RANK   = 2'd2,
    MODE_ADD    = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DONE  = 2'd1,
    ST_FAIL  = 2'd2,
    ST_RETRY = 2'd3
  } pe_st_e;

  typedef struct packed {
    logic commit;     // a write will be issued this cycle
    logic useSum;     // store the combined sum
    logic needEqual;  // all-agree check in force
  } strobe_t;
endpackage

// File: rtl/cwr_ctrl.sv
module cwr_ctrl
  import cwr_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [NUM_PE-1:0]        wrValid,
  input  logic [NUM_PE*ADDR_W-1:0] wrAddr,
  input  logic                     allEqual,
  output strobe_t                  strb,
  output logic [NUM_PE-1:0]        contMask,
  output logic [IDX_W-1:0]         winIdx,
  output logic [ADDR_W-1:0]        tgtAddr,
  output logic [2*NUM_PE-1:0]      peStatus
);
  logic [ADDR_W-1:0] addrArr [NUM_PE];
  logic [IDX_W-1:0]  tgtIdx, arbIdx, ptrQ, ptrNext;
  logic              anyValid;
  wmode_e            modeE;
  logic [1:0]        stNext [NUM_PE];

  assign modeE    = wmode_e'(mode);
  assign anyValid = |wrValid;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_addr
    assign addrArr[g]  = wrAddr[g*ADDR_W +: ADDR_W];
    assign contMask[g] = wrValid[g] && (addrArr[g] == tgtAddr);
  end

  // lowest-index valid writer defines the address served this cycle
  always_comb begin
    tgtIdx = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (wrValid[i]) tgtIdx = IDX_W'(i);
    end
  end
  assign tgtAddr = addrArr[tgtIdx];

  // rotating choice: first contender at or above the pointer, wrapping
  always_comb begin
    arbIdx = tgtIdx;
    for (int k = NUM_PE - 1; k >= 0; k--) begin
      int j;
      j = int'(ptrQ) + k;
      if (j >= NUM_PE) j = j - NUM_PE;
      if (contMask[j]) arbIdx = IDX_W'(j);
    end
  end

  assign winIdx = (modeE == MODE_ROTATE) ? arbIdx : tgtIdx;

  always_comb begin
    strb.needEqual = (modeE == MODE_AGREE);
    strb.useSum    = (modeE == MODE_ADD);
    strb.commit    = anyValid && ((modeE != MODE_AGREE) || allEqual);
  end

  always_comb begin
    for (int i = 0; i < NUM_PE; i++) begin
      if (!wrValid[i])       stNext[i] = ST_IDLE;
      else if (!contMask[i]) stNext[i] = ST_RETRY;
      else begin
        unique case (modeE)
          MODE_AGREE: stNext[i] = allEqual ? ST_DONE : ST_FAIL;
          MODE_ADD:   stNext[i] = ST_DONE;
          default:    stNext[i] = (IDX_W'(i) == winIdx) ? ST_DONE : ST_FAIL;
        endcase
      end
    end
  end

  assign ptrNext = (winIdx == IDX_W'(NUM_PE - 1)) ? '0 : winIdx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ     <= '0;
      peStatus <= '0;
    end else begin
      if (anyValid && modeE == MODE_ROTATE) ptrQ <= ptrNext;
      for (int i = 0; i < NUM_PE; i++) peStatus[2*i +: 2] <= stNext[i];
    end
  end
endmodule

// File: rtl/cwr_datapath.sv
module cwr_datapath
  import cwr_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int SUM_W = DATA_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  strb,
  input  logic [NUM_PE-1:0]        contMask,
  input  logic [IDX_W-1:0]         winIdx,
  input  logic [ADDR_W-1:0]        tgtAddr,
  input  logic [NUM_PE*DATA_W-1:0] wrData,
  output logic                     allEqual,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memData,
  output logic                     sumOverflow
);
  logic [DATA_W-1:0] dataArr [NUM_PE];
  logic [DATA_W-1:0] refData, wData;
  logic [SUM_W-1:0]  sumAll;
  logic              ovf;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_data
    assign dataArr[g] = wrData[g*DATA_W +: DATA_W];
  end

  assign refData = dataArr[winIdx];

  always_comb begin
    allEqual = 1'b1;
    sumAll   = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (contMask[i]) begin
        if (dataArr[i] != refData) allEqual = 1'b0;
        sumAll = sumAll + {{IDX_W{1'b0}}, dataArr[i]};
      end
    end
  end

  assign wData = strb.useSum ? sumAll[DATA_W-1:0] : refData;
  assign ovf   = strb.useSum && (|sumAll[SUM_W-1:DATA_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memWe       <= 1'b0;
      memAddr     <= '0;
      memData     <= '0;
      sumOverflow <= 1'b0;
    end else begin
      memWe       <= strb.commit;
      memAddr     <= strb.commit ? tgtAddr : '0;
      memData     <= strb.commit ? wData : '0;
      sumOverflow <= strb.commit && ovf;
    end
  end
endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
  import cwr_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [NUM_PE-1:0]        wrValid,
  input  logic [NUM_PE*ADDR_W-1:0] wrAddr,
  input  logic [NUM_PE*DATA_W-1:0] wrData,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memData,
  output logic                     sumOverflow,
  output logic [2*NUM_PE-1:0]      peStatus
);
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

  strobe_t           strb;
  logic [NUM_PE-1:0] contMask;
  logic [IDX_W-1:0]  winIdx;
  logic [ADDR_W-1:0] tgtAddr;
  logic              allEqual;

  cwr_ctrl #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wrValid(wrValid),
    .wrAddr(wrAddr), .allEqual(allEqual), .strb(strb),
    .contMask(contMask), .winIdx(winIdx), .tgtAddr(tgtAddr),
    .peStatus(peStatus)
  );

  cwr_datapath #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .contMask(contMask),
    .winIdx(winIdx), .tgtAddr(tgtAddr), .wrData(wrData),
    .allEqual(allEqual), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .sumOverflow(sumOverflow)
  );
endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode,
  input logic [NUM_PE-1:0]        wrValid,
  input logic [NUM_PE*ADDR_W-1:0] wrAddr,
  input logic [NUM_PE*DATA_W-1:0] wrData,
  input logic                     memWe,
  input logic [ADDR_W-1:0]        memAddr,
  input logic [DATA_W-1:0]        memData,
  input logic                     sumOverflow,
  input logic [2*NUM_PE-1:0]      peStatus
);
  logic [NUM_PE-1:0] doneMask;
  for (genvar g = 0; g < NUM_PE; g++) begin : g_done
    assign doneMask[g] = (peStatus[2*g +: 2] == 2'd1);
  end

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wrValid) |=> !memWe && memAddr == '0 && memData == '0);

  // R5
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && |wrValid) |=> $countones(doneMask) == 1);

  // R5
  rank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wrValid[0]) |=> peStatus[1:0] == 2'd1);

  // R8
  overflow_sum_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sumOverflow |-> memWe && $past(mode) == 2'd3);

  // R4
  no_write_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memWe |-> doneMask == '0);

  // R3
  lowest_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid[0] |=> peStatus[1:0] != 2'd3);
endmodule

bind cw_resolver cwr_checker #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/cw_resolver_tb_top.sv
module cw_resolver_tb_top;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          ovf;
    logic [2*NP-1:0] st;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NP-1:0] wrValid = '0;
  logic [NP*AW-1:0] wrAddr = '0;
  logic [NP*DW-1:0] wrData = '0;
  logic memWe, sumOverflow;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic [2*NP-1:0] peStatus;

  int checks = 0;
  int failures = 0;
  int ptrModel = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  cw_resolver #(.NUM_PE(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .sumOverflow(sumOverflow), .peStatus(peStatus)
  );

  // driver: applies one request set on a falling edge and queues its outcome
  task automatic drive(input logic [1:0] m, input logic [NP-1:0] v,
                       input logic [NP*AW-1:0] a, input logic [NP*DW-1:0] d,
                       input string req);
    exp_t e;
    int tgt, win, sum;
    logic eq;
    logic [NP-1:0] cont;
    @(negedge clk);
    mode = m; wrValid = v; wrAddr = a; wrData = d;
    e.we = 0; e.addr = 0; e.data = 0; e.ovf = 0; e.st = 0; e.req = req;
    tgt = -1;
    for (int i = 0; i < NP; i++) if (v[i] && tgt < 0) tgt = i;
    if (tgt >= 0) begin
      for (int i = 0; i < NP; i++)
        cont[i] = v[i] && (a[i*AW +: AW] == a[tgt*AW +: AW]);
      for (int i = 0; i < NP; i++)
        if (v[i] && !cont[i]) e.st[2*i +: 2] = 2'd3;
      win = tgt;
      if (m == 2'd1) begin
        for (int k = 0; k < NP; k++) begin
          int j = (ptrModel + k) % NP;
          if (cont[j]) begin win = j; break; end
        end
        ptrModel = (win + 1) % NP;
      end
      eq = 1'b1; sum = 0;
      for (int i = 0; i < NP; i++) if (cont[i]) begin
        if (d[i*DW +: DW] != d[tgt*DW +: DW]) eq = 1'b0;
        sum += int'(d[i*DW +: DW]);
      end
      case (m)
        2'd0: begin
          e.we = eq;
          for (int i = 0; i < NP; i++) if (cont[i]) e.st[2*i +: 2] = eq ? 2'd1 : 2'd2;
          if (eq) e.data = d[tgt*DW +: DW];
        end
        2'd3: begin
          e.we = 1; e.data = DW'(sum % (1 << DW)); e.ovf = (sum >= (1 << DW));
          for (int i = 0; i < NP; i++) if (cont[i]) e.st[2*i +: 2] = 2'd1;
        end
        default: begin
          e.we = 1; e.data = d[win*DW +: DW];
          for (int i = 0; i < NP; i++) if (cont[i]) e.st[2*i +: 2] = (i == win) ? 2'd1 : 2'd2;
        end
      endcase
      if (e.we) e.addr = a[tgt*AW +: AW];
    end
    q.push_back(e);
  endtask

  // monitor: compares one registered result per cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (memWe !== e.we || memAddr !== e.addr || memData !== e.data ||
          sumOverflow !== e.ovf || peStatus !== e.st) begin
        failures++;
        $display("FAIL %s: got we=%0b addr=%0h data=%0h ovf=%0b st=%b, expected we=%0b addr=%0h data=%0h ovf=%0b st=%b",
                 e.req, memWe, memAddr, memData, sumOverflow, peStatus,
                 e.we, e.addr, e.data, e.ovf, e.st);
      end
    end
  end

  initial begin
    #160000;
    failures++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (memWe !== 0 || memAddr !== 0 || memData !== 0 || sumOverflow !== 0 || peStatus !== 0) begin
      failures++;
      $display("FAIL R1: got we=%0b addr=%0h data=%0h ovf=%0b st=%b, expected all zero",
               memWe, memAddr, memData, sumOverflow, peStatus);
    end
    rst_n = 1'b1;
    // R2 single writer, one-cycle latency
    drive(2'd0, 4'b0100, {8'h00, 8'h3C, 8'h00, 8'h00}, {8'h00, 8'h5A, 8'h00, 8'h00}, "R2");
    // R4 agreeing contenders
    drive(2'd0, 4'b1011, {8'h10, 8'h00, 8'h10, 8'h10}, {8'h77, 8'h00, 8'h77, 8'h77}, "R4");
    // R4 disagreeing contenders
    drive(2'd0, 4'b0111, {8'h00, 8'h22, 8'h22, 8'h22}, {8'h00, 8'h01, 8'h01, 8'h02}, "R4");
    // R9 idle cycle
    drive(2'd0, 4'b0000, '0, '0, "R9");
    // R5 ranked, lowest contender wins
    drive(2'd2, 4'b1110, {8'h44, 8'h44, 8'h44, 8'h00}, {8'hD3, 8'hC2, 8'hB1, 8'h00}, "R5");
    // R6 rotating through four contenders
    for (int r = 0; r < 5; r++)
      drive(2'd1, 4'b1111, {4{8'h55}}, {8'h04, 8'h03, 8'h02, 8'h01}, "R6");
    drive(2'd1, 4'b1010, {8'h66, 8'h00, 8'h66, 8'h00}, {8'hBB, 8'h00, 8'hAA, 8'h00}, "R6");
    drive(2'd1, 4'b1010, {8'h66, 8'h00, 8'h66, 8'h00}, {8'hBB, 8'h00, 8'hAA, 8'h00}, "R6");
    // R7 sum within range
    drive(2'd3, 4'b0111, {8'h00, 8'h09, 8'h09, 8'h09}, {8'h00, 8'h30, 8'h20, 8'h10}, "R7");
    // R8 sum overflow wraps
    drive(2'd3, 4'b1111, {4{8'h0A}}, {8'h80, 8'h70, 8'h60, 8'h50}, "R8");
    // R8 large values in ranked mode do not raise overflow
    drive(2'd2, 4'b1111, {4{8'h0A}}, {8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R8");
    // R3 mixed addresses: retry for the others
    drive(2'd2, 4'b1101, {8'h12, 8'h34, 8'h00, 8'h34}, {8'h9, 8'h8, 8'h0, 8'h7}, "R3");
    drive(2'd3, 4'b1110, {8'h77, 8'h77, 8'h99, 8'h00}, {8'h05, 8'h06, 8'h07, 8'h00}, "R3");
    // R10 mode change applies at once, same requests
    drive(2'd0, 4'b0011, {8'h00, 8'h00, 8'h21, 8'h21}, {8'h00, 8'h00, 8'h02, 8'h01}, "R10");
    drive(2'd3, 4'b0011, {8'h00, 8'h00, 8'h21, 8'h21}, {8'h00, 8'h00, 8'h02, 8'h01}, "R10");
    drive(2'd0, 4'b0000, '0, '0, "R9");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule